// File: doc/BRIEF.md
# Flag-Mask Conditional Branch and Call Resolver

This block makes the branch decision for the jump class of an 8-bit opcode set. A jump-class opcode has a zero upper nibble. The low three opcode bits form a mask, and each set bit names a status flag that must be 1 for the branch to be taken. Bit 0 names carry, bit 1 names zero and bit 2 names sign. An empty mask means the branch always goes. Opcode bit 3 turns the branch into a call. A taken call also writes a link address into the index register, so that a later return can resume after the call.

All outputs are combinational from the inputs. The execute-stage sequencer presents the opcode, the flags, the 16-bit absolute target and the address of the current 3-byte instruction. On the same clock edge it captures the taken indication, the next program counter and the index-register write. The block keeps no state, and it has no output that could change a flag.

Top module: `flagmask_branch_unit`

## Requirements
- R1: For a jump-class opcode (bits 7:4 = 0000), `take_o` is 1 exactly when every flag selected by opcode bits 2:0 is 1. Bit 0 selects `flag_c_i`, bit 1 selects `flag_z_i` and bit 2 selects `flag_n_i`.
- R2: A jump-class opcode with bits 2:0 = 000 gives `take_o` = 1 for every combination of flag values.
- R3: An opcode whose bits 7:4 are not 0000 gives `take_o` = 0 and `x_we_o` = 0, whatever the flags are.
- R4: When `take_o` is 1, `next_pc_o` equals `target_i`.
- R5: When `take_o` is 0, `next_pc_o` equals `instr_addr_i + 3` modulo 2^16. This is the address of the byte after the 3-byte instruction.
- R6: When `take_o` is 1 and opcode bit 3 is 1, `x_we_o` is 1.
- R7: When opcode bit 3 is 0, `x_we_o` is 0.
- R8: When `take_o` is 0, `x_we_o` is 0.
- R9: `x_data_o` always equals `instr_addr_i + 3` modulo 2^16, so a taken call links to the byte after itself. This includes the case where the sum wraps past 0xFFFF.
- R10: The outputs follow an input change within the same clock cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 8 | Opcode of the instruction in execute |
| flag_c_i | input | 1 | Current carry flag |
| flag_z_i | input | 1 | Current zero flag |
| flag_n_i | input | 1 | Current sign flag |
| target_i | input | 16 | Absolute branch target from the operand bytes |
| instr_addr_i | input | 16 | Address of the first byte of the current instruction |
| take_o | output | 1 | Branch taken |
| next_pc_o | output | 16 | Program counter for the next fetch |
| x_we_o | output | 1 | Index register write enable |
| x_data_o | output | 16 | Link address to write into the index register |

## Verification
Two things can happen together in one evaluation: a conditional call is taken, and its link address wraps past 0xFFFF. The pc override and the index write then depend on the same mask decision, and the link wraps while the target does not. The bench builds this case directly, with masks 1xxx, all selected flags set and instruction addresses from 0xFFFD to 0xFFFF. It then expects the target on `next_pc_o`, `x_we_o` high and a small wrapped link value on `x_data_o`. Random opcodes from the jump class and from the other classes, with random flags, test the same pairing when the condition fails: both the override and the write must then drop together.

// File: rtl/flagmask_branch_pkg.sv
// Package: shared widths and field positions for the flag-mask branch resolver.
// Assumes an 8-bit opcode split into a 4-bit class nibble and a 4-bit function nibble.
package flagmask_branch_pkg;
    localparam int OPCODE_W   = 8;
    localparam int CLASS_W    = 4;
    localparam int FUNC_W     = OPCODE_W - CLASS_W;
    localparam int MASK_W     = 3;          // flag-select bits within the function nibble
    localparam int CALL_BIT   = MASK_W;     // function bit that requests a link write
    localparam logic [CLASS_W-1:0] JUMP_CLASS = '0;

    // Flags packed so that bit i lines up with mask bit i.
    typedef struct packed {
        logic sign;
        logic zero;
        logic carry;
    } flag_set_t;

    // Decoded view of a jump-class function nibble.
    typedef struct packed {
        logic              is_call;
        logic [MASK_W-1:0] mask;
    } jump_func_t;
endpackage

// File: rtl/flag_mask_eval.sv
// Module: flag_mask_eval
// Purpose: decides whether every flag named in a select mask is set.
// Assumes: mask bit i and flag bit i refer to the same flag; an empty mask passes.
module flag_mask_eval #(
    parameter int MASK_W = 3
) (
    input  logic [MASK_W-1:0] mask_i,
    input  logic [MASK_W-1:0] flags_i,
    output logic              pass_o
);
    logic [MASK_W-1:0] bit_ok;

    // One term per flag: an unselected flag or a set flag is acceptable.
    generate
        for (genvar g = 0; g < MASK_W; g++) begin : g_term
            assign bit_ok[g] = ~mask_i[g] | flags_i[g];
        end
    endgenerate

    // All terms must agree for the condition to pass.
    assign pass_o = &bit_ok;
endmodule

// File: rtl/seq_addr_gen.sv
// Module: seq_addr_gen
// Purpose: produces the address of the byte after a fixed-length instruction.
// Assumes: addresses wrap modulo 2^ADDR_W.
module seq_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int STEP   = 3
) (
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] next_o
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    // Modular add of the instruction length.
    assign next_o = base_i + STEP_V;
endmodule

// File: rtl/flagmask_branch_unit.sv
// Module: flagmask_branch_unit
// Purpose: execute-stage resolver for jump-class opcodes. It gives the taken flag,
//          the next program counter and an index-register link write for calls.
// Assumes: the caller samples all outputs on the edge that ends the execute cycle;
//          the flags are held outside; no output of this block alters a flag.
module flagmask_branch_unit
    import flagmask_branch_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CALL_BYTES = 3
) (
    input  logic [OPCODE_W-1:0] opcode_i,
    input  logic                flag_c_i,
    input  logic                flag_z_i,
    input  logic                flag_n_i,
    input  logic [ADDR_W-1:0]   target_i,
    input  logic [ADDR_W-1:0]   instr_addr_i,
    output logic                take_o,
    output logic [ADDR_W-1:0]   next_pc_o,
    output logic                x_we_o,
    output logic [ADDR_W-1:0]   x_data_o
);
    logic [CLASS_W-1:0] op_class;
    jump_func_t         func;
    flag_set_t          flags;
    logic               cond_pass;
    logic               class_hit;
    logic [ADDR_W-1:0]  seq_addr;

    // Split the opcode into its class and function fields.
    assign op_class = opcode_i[OPCODE_W-1 -: CLASS_W];
    assign func     = jump_func_t'(opcode_i[FUNC_W-1:0]);

    // Pack the flags so they line up with the mask bits.
    assign flags = '{sign: flag_n_i, zero: flag_z_i, carry: flag_c_i};

    // Evaluate the AND of the selected flags.
    flag_mask_eval #(
        .MASK_W (MASK_W)
    ) u_cond (
        .mask_i  (func.mask),
        .flags_i (flags),
        .pass_o  (cond_pass)
    );

    // Address after the current instruction: fall-through and link value.
    seq_addr_gen #(
        .ADDR_W (ADDR_W),
        .STEP   (CALL_BYTES)
    ) u_seq (
        .base_i (instr_addr_i),
        .next_o (seq_addr)
    );

    // Only the jump class may redirect the flow.
    assign class_hit = (op_class == JUMP_CLASS);

    // Final redirect, pc select and link write.
    always_comb begin
        take_o    = class_hit & cond_pass;
        next_pc_o = take_o ? target_i : seq_addr;
        x_we_o    = take_o & func.is_call;
        x_data_o  = seq_addr;
    end
endmodule

// File: rtl/flagmask_branch_unit_chk.sv
// Module: flagmask_branch_unit_chk
// Purpose: property checks on the resolver ports, attached by bind.
// Assumes: combinational block, so the checks are immediate and are skipped while any input is unknown.
module flagmask_branch_unit_chk #(
    parameter int ADDR_W     = 16,
    parameter int CALL_BYTES = 3
) (
    input logic [7:0]        opcode_i,
    input logic              flag_c_i,
    input logic              flag_z_i,
    input logic              flag_n_i,
    input logic [ADDR_W-1:0] target_i,
    input logic [ADDR_W-1:0] instr_addr_i,
    input logic              take_o,
    input logic [ADDR_W-1:0] next_pc_o,
    input logic              x_we_o,
    input logic [ADDR_W-1:0] x_data_o
);
    logic [ADDR_W-1:0] after_addr;
    logic              known;

    // Expected address after the instruction, for the link and fall-through checks.
    assign after_addr = instr_addr_i + ADDR_W'(CALL_BYTES);
    assign known      = !$isunknown({opcode_i, flag_c_i, flag_z_i, flag_n_i, target_i, instr_addr_i});

    // Evaluate every property whenever the inputs are fully known.
    always_comb begin
        if (known) begin
            // R1
            mask_flags_chk: assert (!take_o || ((!opcode_i[0] || flag_c_i) && (!opcode_i[1] || flag_z_i) && (!opcode_i[2] || flag_n_i)))
                else $error("R1 taken with a selected flag clear");
            // R2
            empty_mask_chk: assert (!(opcode_i[7:4] == 4'h0 && opcode_i[2:0] == 3'b000) || take_o)
                else $error("R2 empty mask not taken");
            // R3
            class_gate_chk: assert (opcode_i[7:4] == 4'h0 || (!take_o && !x_we_o))
                else $error("R3 non-jump class redirected");
            // R4
            taken_pc_chk: assert (!take_o || next_pc_o == target_i)
                else $error("R4 taken pc mismatch");
            // R5
            fall_pc_chk: assert (take_o || next_pc_o == after_addr)
                else $error("R5 fall-through pc mismatch");
            // R6
            call_write_chk: assert (!(take_o && opcode_i[3]) || x_we_o)
                else $error("R6 taken call without link write");
            // R7
            plain_jump_chk: assert (opcode_i[3] || !x_we_o)
                else $error("R7 link write on plain jump");
            // R8
            write_needs_take_chk: assert (take_o || !x_we_o)
                else $error("R8 link write without branch");
            // R9
            link_value_chk: assert (x_data_o == after_addr)
                else $error("R9 link value mismatch");
        end
    end
endmodule

bind flagmask_branch_unit flagmask_branch_unit_chk #(
    .ADDR_W     (ADDR_W),
    .CALL_BYTES (CALL_BYTES)
) u_chk (
    .opcode_i     (opcode_i),
    .flag_c_i     (flag_c_i),
    .flag_z_i     (flag_z_i),
    .flag_n_i     (flag_n_i),
    .target_i     (target_i),
    .instr_addr_i (instr_addr_i),
    .take_o       (take_o),
    .next_pc_o    (next_pc_o),
    .x_we_o       (x_we_o),
    .x_data_o     (x_data_o)
);

// File: tb/flagmask_branch_unit_test.sv
// Bench for flagmask_branch_unit: directed corners plus seeded random stimulus.
module flagmask_branch_unit_test;
    logic        clk = 1'b0;
    logic [7:0]  opcode;
    logic        fc, fz, fn;
    logic [15:0] target, iaddr;
    logic        take;
    logic [15:0] npc;
    logic        xwe;
    logic [15:0] xdata;
    int          total = 0;
    int          bad   = 0;
    bit          done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    flagmask_branch_unit uut (
        .opcode_i     (opcode),
        .flag_c_i     (fc),
        .flag_z_i     (fz),
        .flag_n_i     (fn),
        .target_i     (target),
        .instr_addr_i (iaddr),
        .take_o       (take),
        .next_pc_o    (npc),
        .x_we_o       (xwe),
        .x_data_o     (xdata)
    );

    function automatic logic exp_take(input logic [7:0] op, input logic c, input logic z, input logic n);
        return (op[7:4] == 4'h0) && (!op[0] || c) && (!op[1] || z) && (!op[2] || n);
    endfunction

    function automatic logic [15:0] exp_after(input logic [15:0] a);
        return a + 16'd3;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one vector mid-cycle and compare before the next edge (R10: same cycle).
    task automatic run_vec(input logic [7:0] op, input logic c, input logic z, input logic n,
                           input logic [15:0] tgt, input logic [15:0] ia);
        logic t;
        string treq;
        @(posedge clk);
        #3;
        opcode = op; fc = c; fz = z; fn = n; target = tgt; iaddr = ia;
        #5;
        t = exp_take(op, c, z, n);
        if (op[7:4] != 4'h0)        treq = "R3 take";
        else if (op[2:0] == 3'b000) treq = "R2 take";
        else                        treq = "R1 take";
        check(treq, {31'd0, take}, {31'd0, t});
        check(t ? "R4 next_pc" : "R5 next_pc", {16'd0, npc}, {16'd0, t ? tgt : exp_after(ia)});
        if (!t)        check("R8 x_we", {31'd0, xwe}, 32'd0);
        else if (op[3]) check("R6 x_we", {31'd0, xwe}, 32'd1);
        else           check("R7 x_we", {31'd0, xwe}, 32'd0);
        check("R9 x_data", {16'd0, xdata}, {16'd0, exp_after(ia)});
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        opcode = 8'h00; fc = 0; fz = 0; fn = 0; target = 16'h0000; iaddr = 16'h0000;
        #8;
        // Idle state: all-zero inputs are an unconditional jump to 0 (R2, R4, R10).
        check("R2 idle take", {31'd0, take}, 32'd1);
        check("R4 idle next_pc", {16'd0, npc}, 32'd0);
        check("R7 idle x_we", {31'd0, xwe}, 32'd0);

        // R2: empty mask taken for all eight flag combinations, jump and call forms.
        for (int f = 0; f < 8; f++) begin
            run_vec(8'h00, f[0], f[1], f[2], 16'h1234, 16'h0100);
            run_vec(8'h08, f[0], f[1], f[2], 16'hBEEF, 16'h0200);
        end
        // R1: every mask against every flag pattern.
        for (int m = 1; m < 16; m++)
            for (int f = 0; f < 8; f++)
                run_vec(8'(m), f[0], f[1], f[2], 16'hA5A5, 16'h4000);
        // R6 + R9: taken calls with wrapping link addresses.
        run_vec(8'h0F, 1, 1, 1, 16'h0800, 16'hFFFD);
        run_vec(8'h09, 1, 0, 0, 16'h0900, 16'hFFFE);
        run_vec(8'h0C, 0, 0, 1, 16'h0A00, 16'hFFFF);
        // R5: failed condition with wrap of the fall-through address.
        run_vec(8'h0B, 1, 0, 1, 16'h0B00, 16'hFFFF);
        // R3: other classes never redirect, even with all flags set.
        run_vec(8'h10, 1, 1, 1, 16'h2222, 16'h0010);
        run_vec(8'h37, 1, 1, 1, 16'h3333, 16'h0020);
        run_vec(8'hF0, 1, 1, 1, 16'h4444, 16'h0030);
        run_vec(8'h28, 1, 1, 1, 16'h5555, 16'hFFFE);

        // Seeded random mix, biased toward the jump class.
        void'($urandom(32'h5EED_0042));
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] op;
            op = 8'($urandom());
            if ($urandom_range(0, 1) == 0) op[7:4] = 4'h0;
            run_vec(op, 1'($urandom()), 1'($urandom()), 1'($urandom()),
                    16'($urandom()), 16'($urandom()));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule